// File: doc/BRIEF.md
# ATA PIO Strobe Timing Generator

This block sequences programmed-I/O strobe cycles for a two-channel ATA host with two drives on each channel. The four drive slots each have a timing byte that holds a packed active count and a packed recovery code. Address setup is set by 2-bit codes. On channel 0 each drive has its own code, and the block applies the slower of the pair. On channel 1 a single code is shared by both drives. Software loads these values through a small byte-wide write port.

A transfer request names a slot and a direction. Once the block is idle it accepts the request and latches the decoded counts. It then drives an address-valid phase for the setup time and pulls the read or write strobe low for the active time. After that it holds the strobe high for the recovery time and finally raises a one-cycle done pulse. A request that arrives while a cycle is running is held until the block is idle again.

The block also keeps one interrupt-pending bit per channel. A bit is set on a rising edge of that channel's drive interrupt line, and software clears it by writing a 1. The channel 1 clear bit sits in the same byte as the shared setup code. A setup update that writes 0 there leaves a pending interrupt untouched.

Top module: `ata_strobe_timer`

## Requirements
- R1: After reset, the block is idle: `req_ready_o`=1, `busy_o`=0, `addr_valid_o`=0, both strobes high, `done_o`=0 and `irq_pend_o`=0. The reset timing bytes are 0 and the reset setup codes are 00, so a cycle issued right after reset runs 4 setup, 16 active and 16 recovery clocks.
- R2: Bits 7:4 of a slot's timing byte (register address 0..3, address = {channel, drive}) give the active length. A value of 1..15 means that many clocks, and 0 means 16 clocks.
- R3: Bits 3:0 of the timing byte give the recovery length. Code 0 means 16 clocks, codes 1..14 mean code+1 clocks, and code 15 means 2 clocks.
- R4: Setup codes sit in bits 7:6 of the setup registers. The mapping is 01→2, 10→3, 00→4 and 11→5 clocks.
- R5: Channel 0 has a setup register for drive 0 (address 4) and one for drive 1 (address 5). A cycle to either drive of channel 0 uses the longer of the two decoded setup lengths.
- R6: Channel 1 has one setup register (address 6), which sets the setup length for both of its drives.
- R7: A cycle runs in this order: setup, then active, then recovery. `addr_valid_o` is high through all three phases. During the active phase only the strobe for the requested direction is low (`diow_no` for write=1, `dior_no` for write=0), and the two strobes are never low together.
- R8: `done_o` is high for exactly one clock, directly after the last recovery clock. The block is idle on the following clock.
- R9: `req_ready_o` is low while a cycle runs. A request held during that time is not taken until the block is idle, and it then runs with its own slot and direction.
- R10: `irq_pend_o[c]` is set on a rising edge of `intrq_i[c]`. Holding the line high does not set the bit again after it has been cleared.
- R11: Writing address 7 with bit 2 = 1 clears `irq_pend_o[0]`. Writing the same address with bit 2 = 0 leaves it unchanged.
- R12: Writing address 6 with bit 2 = 1 clears `irq_pend_o[1]`. A setup update to address 6 with bit 2 = 0 leaves it unchanged.
- R13: Counts are latched when a request is accepted. A register write made while a cycle is running only affects later cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| req_valid_i | input | 1 | Transfer request, held until accepted |
| req_slot_i | input | 2 | Drive slot {channel, drive} |
| req_write_i | input | 1 | 1 = write strobe, 0 = read strobe |
| intrq_i | input | 2 | Drive interrupt line per channel |
| req_ready_o | output | 1 | Idle; a valid request is taken on this clock |
| busy_o | output | 1 | Cycle in progress |
| addr_valid_o | output | 1 | Address phase active |
| dior_no | output | 1 | Read strobe, active low |
| diow_no | output | 1 | Write strobe, active low |
| done_o | output | 1 | One-clock end-of-cycle pulse |
| irq_pend_o | output | 2 | Interrupt-pending bit per channel |

## Verification
The assertions check on every cycle that the two strobes are never low together and that no strobe is low without a valid address. They also check that done lasts one clock and is followed by idle, and that the interrupt clear and preserve rules hold. The lengths of the three phases, the setup merge on channel 0, the sharing on channel 1, the holding of a request that arrives mid-cycle and the latching of counts at acceptance can only be shown by the bench. It counts the clocks of each phase for chosen register contents and compares them with the decode tables.

// File: rtl/ata_tim_pkg.sv
package ata_tim_pkg;

  localparam int CNT_W = 5;

  localparam logic [2:0] ADDR_SU_C0D0 = 3'd4;
  localparam logic [2:0] ADDR_SU_C0D1 = 3'd5;
  localparam logic [2:0] ADDR_SU_C1   = 3'd6;
  localparam logic [2:0] ADDR_IRQ_C0  = 3'd7;
  localparam int         IRQ_CLR_BIT  = 2;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_ACTIVE, ST_RECOV, ST_DONE
  } seq_state_e;

  typedef struct packed {
    logic [CNT_W-1:0] su;
    logic [CNT_W-1:0] act;
    logic [CNT_W-1:0] rec;
  } phase_cnt_t;

  function automatic logic [CNT_W-1:0] setup_clks(input logic [1:0] code);
    case (code)
      2'b01:   return CNT_W'(2);
      2'b10:   return CNT_W'(3);
      2'b00:   return CNT_W'(4);
      default: return CNT_W'(5);
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] active_clks(input logic [3:0] f);
    return (f == 4'd0) ? CNT_W'(16) : {1'b0, f};
  endfunction

  // code 15 is the minimum-recovery setting
  function automatic logic [CNT_W-1:0] recov_clks(input logic [3:0] c);
    if (c == 4'd0)  return CNT_W'(16);
    if (c == 4'd15) return CNT_W'(2);
    return {1'b0, c} + CNT_W'(1);
  endfunction

endpackage

// File: rtl/ata_tim_regs.sv
module ata_tim_regs
  import ata_tim_pkg::*;
#(
  parameter int NUM_CH    = 2,
  parameter int NUM_SLOTS = 4
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        we_i,
  input  logic [2:0]                  addr_i,
  input  logic [7:0]                  wdata_i,
  input  logic [NUM_CH-1:0]           intrq_i,
  output logic [NUM_SLOTS-1:0][7:0]   tim_o,
  output logic [2:0][1:0]             su_o,
  output logic [NUM_CH-1:0]           irq_pend_o
);

  logic [NUM_SLOTS-1:0][7:0] tim_q;
  logic [2:0][1:0]           su_q;
  logic [NUM_CH-1:0]         intrq_q;
  logic [NUM_CH-1:0]         pend_q;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_tim
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                tim_q[s] <= '0;
      else if (we_i && addr_i == 3'(s))           tim_q[s] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      su_q <= '0;
    end else if (we_i) begin
      if (addr_i == ADDR_SU_C0D0) su_q[0] <= wdata_i[7:6];
      if (addr_i == ADDR_SU_C0D1) su_q[1] <= wdata_i[7:6];
      if (addr_i == ADDR_SU_C1)   su_q[2] <= wdata_i[7:6];
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_irq
    localparam logic [2:0] CLR_ADDR = (c == 0) ? ADDR_IRQ_C0 : ADDR_SU_C1;
    logic rise, clr;
    assign rise = intrq_i[c] & ~intrq_q[c];
    assign clr  = we_i && (addr_i == CLR_ADDR) && wdata_i[IRQ_CLR_BIT];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        intrq_q[c] <= 1'b0;
        pend_q[c]  <= 1'b0;
      end else begin
        intrq_q[c] <= intrq_i[c];
        if (rise)     pend_q[c] <= 1'b1;
        else if (clr) pend_q[c] <= 1'b0;
      end
    end
  end

  assign tim_o      = tim_q;
  assign su_o       = su_q;
  assign irq_pend_o = pend_q;

endmodule

// File: rtl/ata_tim_decode.sv
module ata_tim_decode
  import ata_tim_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic [NUM_SLOTS-1:0][7:0] tim_i,
  input  logic [2:0][1:0]           su_i,
  input  logic [SLOT_W-1:0]         slot_i,
  output phase_cnt_t                cnt_o
);

  logic [CNT_W-1:0] su_d0, su_d1, su_c0;
  logic [7:0]       tbyte;

  assign su_d0 = setup_clks(su_i[0]);
  assign su_d1 = setup_clks(su_i[1]);
  assign su_c0 = (su_d0 > su_d1) ? su_d0 : su_d1;
  assign tbyte = tim_i[slot_i];

  always_comb begin
    cnt_o.su  = slot_i[SLOT_W-1] ? setup_clks(su_i[2]) : su_c0;
    cnt_o.act = active_clks(tbyte[7:4]);
    cnt_o.rec = recov_clks(tbyte[3:0]);
  end

endmodule

// File: rtl/ata_tim_seq.sv
module ata_tim_seq
  import ata_tim_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_valid_i,
  input  logic        req_write_i,
  input  phase_cnt_t  cnt_i,
  output logic        ready_o,
  output logic        busy_o,
  output logic        addr_valid_o,
  output logic        dior_no,
  output logic        diow_no,
  output logic        done_o
);

  seq_state_e       state_q;
  logic [CNT_W-1:0] cnt_q, act_q, rec_q;
  logic             wr_q;
  logic             last;

  assign last = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      act_q   <= '0;
      rec_q   <= '0;
      wr_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          state_q <= ST_SETUP;
          cnt_q   <= cnt_i.su - CNT_W'(1);
          act_q   <= cnt_i.act;
          rec_q   <= cnt_i.rec;
          wr_q    <= req_write_i;
        end
        ST_SETUP: if (last) begin
          state_q <= ST_ACTIVE;
          cnt_q   <= act_q - CNT_W'(1);
        end else cnt_q <= cnt_q - CNT_W'(1);
        ST_ACTIVE: if (last) begin
          state_q <= ST_RECOV;
          cnt_q   <= rec_q - CNT_W'(1);
        end else cnt_q <= cnt_q - CNT_W'(1);
        ST_RECOV: if (last) state_q <= ST_DONE;
                  else      cnt_q   <= cnt_q - CNT_W'(1);
        ST_DONE:  state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  assign ready_o      = (state_q == ST_IDLE);
  assign busy_o       = (state_q != ST_IDLE);
  assign addr_valid_o = (state_q == ST_SETUP) || (state_q == ST_ACTIVE) ||
                        (state_q == ST_RECOV);
  assign dior_no      = !((state_q == ST_ACTIVE) && !wr_q);
  assign diow_no      = !((state_q == ST_ACTIVE) &&  wr_q);
  assign done_o       = (state_q == ST_DONE);

endmodule

// File: rtl/ata_strobe_timer.sv
module ata_strobe_timer
  import ata_tim_pkg::*;
#(
  parameter int  NUM_CH    = 2,
  localparam int NUM_SLOTS = NUM_CH * 2,
  localparam int SLOT_W    = $clog2(NUM_SLOTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [7:0]        reg_wdata_i,
  input  logic              req_valid_i,
  input  logic [SLOT_W-1:0] req_slot_i,
  input  logic              req_write_i,
  input  logic [NUM_CH-1:0] intrq_i,
  output logic              req_ready_o,
  output logic              busy_o,
  output logic              addr_valid_o,
  output logic              dior_no,
  output logic              diow_no,
  output logic              done_o,
  output logic [NUM_CH-1:0] irq_pend_o
);

  logic [NUM_SLOTS-1:0][7:0] tim;
  logic [2:0][1:0]           su;
  phase_cnt_t                cnt;

  ata_tim_regs #(.NUM_CH(NUM_CH), .NUM_SLOTS(NUM_SLOTS)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (reg_we_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .intrq_i    (intrq_i),
    .tim_o      (tim),
    .su_o       (su),
    .irq_pend_o (irq_pend_o)
  );

  ata_tim_decode #(.NUM_SLOTS(NUM_SLOTS)) u_dec (
    .tim_i  (tim),
    .su_i   (su),
    .slot_i (req_slot_i),
    .cnt_o  (cnt)
  );

  ata_tim_seq u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_valid_i  (req_valid_i),
    .req_write_i  (req_write_i),
    .cnt_i        (cnt),
    .ready_o      (req_ready_o),
    .busy_o       (busy_o),
    .addr_valid_o (addr_valid_o),
    .dior_no      (dior_no),
    .diow_no      (diow_no),
    .done_o       (done_o)
  );

endmodule

// File: rtl/ata_strobe_timer_chk.sv
module ata_strobe_timer_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       reg_we_i,
  input logic [2:0] reg_addr_i,
  input logic [7:0] reg_wdata_i,
  input logic [1:0] intrq_i,
  input logic       req_ready_o,
  input logic       addr_valid_o,
  input logic       dior_no,
  input logic       diow_no,
  input logic       done_o,
  input logic [1:0] irq_pend_o
);

  // R7
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!dior_no && !diow_no));

  // R7
  strobe_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dior_no || !diow_no) |-> addr_valid_o);

  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R8
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> req_ready_o && !addr_valid_o);

  // R10
  irq_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (intrq_i[1] && !$past(intrq_i[1])) |=> irq_pend_o[1]);

  // R11
  irq0_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == 3'd7 && reg_wdata_i[2] && !intrq_i[0])
      |=> !irq_pend_o[0]);

  // R12
  irq1_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == 3'd6 && !reg_wdata_i[2] && irq_pend_o[1])
      |=> irq_pend_o[1]);

endmodule

bind ata_strobe_timer ata_strobe_timer_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .reg_we_i     (reg_we_i),
  .reg_addr_i   (reg_addr_i),
  .reg_wdata_i  (reg_wdata_i),
  .intrq_i      (intrq_i),
  .req_ready_o  (req_ready_o),
  .addr_valid_o (addr_valid_o),
  .dior_no      (dior_no),
  .diow_no      (diow_no),
  .done_o       (done_o),
  .irq_pend_o   (irq_pend_o)
);

// File: tb/ata_strobe_timer_test.sv
module ata_strobe_timer_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic       req_valid = 1'b0;
  logic [1:0] req_slot = '0;
  logic       req_write = 1'b0;
  logic [1:0] intrq = '0;
  logic       ready, busy, addr_valid, dior_n, diow_n, done;
  logic [1:0] irq_pend;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  ata_strobe_timer uut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .req_valid_i(req_valid), .req_slot_i(req_slot), .req_write_i(req_write),
    .intrq_i(intrq),
    .req_ready_o(ready), .busy_o(busy), .addr_valid_o(addr_valid),
    .dior_no(dior_n), .diow_no(diow_n), .done_o(done), .irq_pend_o(irq_pend)
  );

  // {slot, write, timing byte, setup a, setup b, exp setup, exp active, exp recovery}
  localparam int NV = 9;
  localparam logic [29:0] VEC [NV] = '{
    {2'd0, 1'b0, 8'h32, 2'b01, 2'b01, 5'd2,  5'd3,  5'd3},
    {2'd1, 1'b1, 8'h05, 2'b01, 2'b10, 5'd3,  5'd16, 5'd6},
    {2'd0, 1'b0, 8'h1F, 2'b00, 2'b01, 5'd4,  5'd1,  5'd2},
    {2'd1, 1'b1, 8'hF0, 2'b11, 2'b10, 5'd5,  5'd15, 5'd16},
    {2'd1, 1'b0, 8'h21, 2'b11, 2'b01, 5'd5,  5'd2,  5'd2},
    {2'd2, 1'b0, 8'h4E, 2'b10, 2'b00, 5'd3,  5'd4,  5'd15},
    {2'd3, 1'b1, 8'h21, 2'b11, 2'b00, 5'd5,  5'd2,  5'd2},
    {2'd3, 1'b0, 8'h81, 2'b01, 2'b00, 5'd2,  5'd8,  5'd2},
    {2'd2, 1'b1, 8'h00, 2'b00, 2'b00, 5'd4,  5'd16, 5'd16}
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  // returns at the first setup-phase negedge, request dropped
  task automatic issue(input logic [1:0] slot, input logic wr);
    req_valid = 1'b1; req_slot = slot; req_write = wr;
    while (!ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic measure(input logic wr, input bit poke, input logic [2:0] pa,
                         input logic [7:0] pd, output int s, output int a,
                         output int r, output int wrong, output int seen);
    int phase = 0;
    s = 0; a = 0; r = 0; wrong = 0; seen = 0;
    for (int idx = 0; idx < 120; idx++) begin
      if (poke && idx == 1) begin reg_we = 1'b1; reg_addr = pa; reg_wdata = pd; end
      if (poke && idx == 2) reg_we = 1'b0;
      if (done) begin seen = 1; break; end
      if (!dior_n || !diow_n) begin
        a++; phase = 1;
        if (wr ? !dior_n : !diow_n) wrong = 1;
        if (!addr_valid) wrong = 1;
      end else if (addr_valid) begin
        if (phase == 0) s++; else r++;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    int s, a, r, wrong, seen;
    logic [29:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 ready", ready, 1);
    chk("R1 busy", busy, 0);
    chk("R1 addr_valid", addr_valid, 0);
    chk("R1 strobes", {dior_n, diow_n}, 3);
    chk("R1 done", done, 0);
    chk("R1 irq_pend", irq_pend, 0);
    issue(2'd1, 1'b0);
    measure(1'b0, 1'b0, 3'd0, 8'd0, s, a, r, wrong, seen);
    chk("R1 reset setup", s, 4);
    chk("R1 reset active", a, 16);
    chk("R1 reset recovery", r, 16);
    @(negedge clk);

    // table walk: R2 R3 R4 R5 R6 R7 R8
    for (int i = 0; i < NV; i++) begin
      v = VEC[i];
      if (!v[29]) begin
        wr_reg(3'd4, {v[18:17], 6'b0});
        wr_reg(3'd5, {v[16:15], 6'b0});
      end else begin
        wr_reg(3'd6, {v[18:17], 6'b0});
      end
      wr_reg({1'b0, v[29:28]}, v[26:19]);
      issue(v[29:28], v[27]);
      measure(v[27], 1'b0, 3'd0, 8'd0, s, a, r, wrong, seen);
      chk(v[29] ? "R6 R4 shared setup" : "R5 R4 merged setup", s, int'(v[14:10]));
      chk("R2 active", a, int'(v[9:5]));
      chk("R3 recovery", r, int'(v[4:0]));
      chk("R7 strobe direction", wrong, 0);
      chk("R8 done seen", seen, 1);
      @(negedge clk);
      chk("R8 idle after done", busy, 0);
    end

    // R9 request held during a cycle
    wr_reg(3'd4, 8'h40); wr_reg(3'd5, 8'h40); wr_reg(3'd0, 8'h22);
    wr_reg(3'd6, 8'h80); wr_reg(3'd2, 8'h13);
    req_valid = 1'b1; req_slot = 2'd0; req_write = 1'b0;
    while (!ready) @(negedge clk);
    @(negedge clk);
    req_slot = 2'd2; req_write = 1'b1;
    chk("R9 ready low mid-cycle", ready, 0);
    measure(1'b0, 1'b0, 3'd0, 8'd0, s, a, r, wrong, seen);
    chk("R9 first setup", s, 2);
    chk("R9 first active", a, 2);
    chk("R9 first recovery", r, 3);
    chk("R9 first read strobe only", wrong, 0);
    @(negedge clk);
    chk("R9 idle before held request", ready, 1);
    @(negedge clk);
    req_valid = 1'b0;
    measure(1'b1, 1'b0, 3'd0, 8'd0, s, a, r, wrong, seen);
    chk("R9 held setup", s, 3);
    chk("R9 held active", a, 1);
    chk("R9 held recovery", r, 4);
    chk("R9 held write strobe", wrong, 0);
    @(negedge clk);

    // R13 counts latched at acceptance
    wr_reg(3'd6, 8'h40); wr_reg(3'd3, 8'h33);
    issue(2'd3, 1'b0);
    measure(1'b0, 1'b1, 3'd3, 8'h5A, s, a, r, wrong, seen);
    chk("R13 old setup", s, 2);
    chk("R13 old active", a, 3);
    chk("R13 old recovery", r, 4);
    @(negedge clk);
    issue(2'd3, 1'b0);
    measure(1'b0, 1'b0, 3'd0, 8'd0, s, a, r, wrong, seen);
    chk("R13 new active", a, 5);
    chk("R13 new recovery", r, 11);
    @(negedge clk);

    // R10 R11 channel 0 interrupt
    intrq[0] = 1'b1;
    @(negedge clk);
    chk("R10 ch0 set on rise", irq_pend, 2'b01);
    wr_reg(3'd7, 8'h00);
    chk("R11 write 0 keeps", irq_pend[0], 1);
    wr_reg(3'd7, 8'h04);
    chk("R11 write 1 clears", irq_pend[0], 0);
    repeat (3) @(negedge clk);
    chk("R10 level held no reset", irq_pend[0], 0);
    intrq[0] = 1'b0;
    @(negedge clk);

    // R10 R12 channel 1 interrupt
    intrq[1] = 1'b1;
    @(negedge clk);
    chk("R10 ch1 set on rise", irq_pend, 2'b10);
    wr_reg(3'd6, 8'h40);
    chk("R12 setup write keeps pending", irq_pend[1], 1);
    wr_reg(3'd7, 8'h04);
    chk("R12 ch0 clear leaves ch1", irq_pend[1], 1);
    wr_reg(3'd6, 8'h44);
    chk("R12 write 1 clears", irq_pend[1], 0);
    intrq[1] = 1'b0;
    @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule